// File: doc/BRIEF.md
# Speculative Read Gate with Learned Page Types

This block sits between an out-of-order core and a system bus and controls which of the core's memory reads reach the bus while they are still speculative. Each read the core hands over gets one of eight transaction slots, and the slot number goes back to the core as the read's id. Every read the gate sends carries a one-bit tag that says whether the read is still speculative. A target that maps device registers may refuse a speculative read. It answers with a refusal that also reports whether the region is I/O, and it performs no access. The gate then parks the refused read until the core either commits the id, which sends the read again with the tag cleared, or squashes it, which drops the read.

To avoid a refusal round trip on every touch of a device page, the gate keeps a small table of pages it has learned are I/O. A speculative read that hits such a page is parked at once and never reaches the bus. A read that misses the table, or any non-speculative read, is sent as normal. Every bus request receives exactly one response, and a slot is freed only when that response arrives, so the gate needs no timeout. When the core squashes a read that is already on the bus, the slot is marked and the late response is thrown away. A refusal of a non-speculative read breaks the protocol and sets a sticky error flag.

Top module: `spg_gate`

## Requirements
- R1: A bus request has `bus_req_spec`=1 exactly when the read was accepted with `req_spec`=1 and had not been committed before the cycle it was issued. A request is taken when `bus_req_valid` and `bus_req_ready` are both 1.
- R2: A refusal (`bus_rsp_nack`=1) of a speculative read parks the slot, and no bus request for that id follows until a commit (`cs_valid`=1, `cs_squash`=0) names it. After the commit the read is sent once more with `bus_req_spec`=0.
- R3: A refusal with `bus_rsp_io`=1 records the page (address bits [31:12]). A later speculative read to a recorded page is parked without any bus request, and a commit then sends it with the tag cleared.
- R4: A non-speculative read is always sent to the bus, even when its page is recorded as I/O.
- R5: The page table has 4 entries and is filled in round-robin order starting at entry 0 after reset or flush, so a fifth distinct page evicts the oldest. A page already present is not added again. A read that misses the table is sent as normal. `tc_flush`=1 empties the table, and a flush wins over a recording in the same cycle.
- R6: There are 8 slots. `req_ready` is 1 while at least one slot is free, and `req_gnt_id` gives the lowest free slot, which becomes the id of a read accepted in that cycle. While every slot is busy, `req_ready` is 0.
- R7: A squash (`cs_squash`=1) of a parked or not-yet-issued id frees the slot with no bus request. A squash of an id that is on the bus, including one issued in the same cycle, makes the gate drop its response: no `core_rsp_valid` follows, and the slot is freed when the response arrives.
- R8: When the gate picks the next bus request, committed parked reads take priority over reads that have not yet been sent, and within each group the lowest id goes first.
- R9: A refusal of a read that was sent with the tag cleared sets `nack_err`, which stays 1 until reset. The slot is freed and nothing is forwarded to the core.
- R10: A data response (`bus_rsp_nack`=0) for a live id appears on `core_rsp_valid`/`core_rsp_id`/`core_rsp_data` in the next cycle, and the slot is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_flush | input | 1 | Empties the learned page table |
| req_valid | input | 1 | Core offers a read |
| req_addr | input | 32 | Read address |
| req_spec | input | 1 | Read is speculative |
| req_ready | output | 1 | A slot is free; a read is accepted this cycle |
| req_gnt_id | output | 3 | Id given to a read accepted this cycle |
| cs_valid | input | 1 | Commit or squash event |
| cs_id | input | 3 | Id of the event |
| cs_squash | input | 1 | 1 squash, 0 commit |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_ready | input | 1 | Bus takes the request |
| bus_req_id | output | 3 | Request id |
| bus_req_addr | output | 32 | Request address |
| bus_req_spec | output | 1 | Speculative tag |
| bus_rsp_valid | input | 1 | Bus response |
| bus_rsp_id | input | 3 | Response id |
| bus_rsp_nack | input | 1 | Response is a refusal |
| bus_rsp_io | input | 1 | Region type with a refusal: 1 = I/O |
| bus_rsp_data | input | 32 | Read data |
| core_rsp_valid | output | 1 | Data returned to the core |
| core_rsp_id | output | 3 | Id of returned data |
| core_rsp_data | output | 32 | Returned data |
| nack_err | output | 1 | Sticky protocol error: a non-speculative read was refused |

## Verification
The hardest states to reach are those where two events meet in one cycle: a squash that lands on the same edge as its read's issue, and a queue in which committed parked reads and unsent new reads wait side by side. The bench reaches both by holding `bus_req_ready` low while it parks reads on a learned I/O page, commits them in reverse id order behind an unsent read, and then releases the bus. It also sends a squash on the negedge right after acceptance, so that the squash and the issue share an edge. Eviction order is brought out through whether later probes of evicted and retained pages reach the bus.

// File: rtl/spg_pkg.sv
package spg_pkg;
    typedef enum logic [2:0] {
        ENT_FREE  = 3'd0,
        ENT_ISSUE = 3'd1,
        ENT_INFL  = 3'd2,
        ENT_PARK  = 3'd3,
        ENT_RETRY = 3'd4
    } ent_st_e;
endpackage

// File: rtl/spg_pick.sv
module spg_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/spg_type_cache.sv
module spg_type_cache #(
    parameter int ENTRIES = 4,
    parameter int PW      = 20,
    localparam int RW = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [PW-1:0]      lk_page,
    output logic               lk_hit,
    input  logic               ins_v,
    input  logic [PW-1:0]      ins_page,
    output logic [ENTRIES-1:0] occ
);
    typedef struct packed {
        logic [ENTRIES-1:0]         vld;
        logic [ENTRIES-1:0][PW-1:0] page;
        logic [RW-1:0]              rr;
    } tc_t;

    tc_t tc_d, tc_q;
    logic [ENTRIES-1:0] lk_m, ins_m;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign lk_m[g]  = tc_q.vld[g] && (tc_q.page[g] == lk_page);
        assign ins_m[g] = tc_q.vld[g] && (tc_q.page[g] == ins_page);
    end

    assign lk_hit = |lk_m;
    assign occ    = tc_q.vld;

    always_comb begin
        tc_d = tc_q;
        if (flush) begin
            tc_d.vld = '0;
            tc_d.rr  = '0;
        end else if (ins_v && !(|ins_m)) begin
            tc_d.vld[tc_q.rr]  = 1'b1;
            tc_d.page[tc_q.rr] = ins_page;
            tc_d.rr = (tc_q.rr == RW'(ENTRIES - 1)) ? '0 : tc_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tc_q <= '0;
        else        tc_q <= tc_d;
    end
endmodule

// File: rtl/spg_gate.sv
module spg_gate #(
    parameter int NUM_ID     = 8,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int TC_ENTRIES = 4,
    parameter int PAGE_SHIFT = 12,
    localparam int IDW = $clog2(NUM_ID),
    localparam int PW  = AW - PAGE_SHIFT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tc_flush,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    input  logic           req_spec,
    output logic           req_ready,
    output logic [IDW-1:0] req_gnt_id,
    input  logic           cs_valid,
    input  logic [IDW-1:0] cs_id,
    input  logic           cs_squash,
    output logic           bus_req_valid,
    input  logic           bus_req_ready,
    output logic [IDW-1:0] bus_req_id,
    output logic [AW-1:0]  bus_req_addr,
    output logic           bus_req_spec,
    input  logic           bus_rsp_valid,
    input  logic [IDW-1:0] bus_rsp_id,
    input  logic           bus_rsp_nack,
    input  logic           bus_rsp_io,
    input  logic [DW-1:0]  bus_rsp_data,
    output logic           core_rsp_valid,
    output logic [IDW-1:0] core_rsp_id,
    output logic [DW-1:0]  core_rsp_data,
    output logic           nack_err
);
    import spg_pkg::*;

    typedef struct packed {
        ent_st_e       st;
        logic          spec;
        logic          sent_spec;
        logic          drop;
        logic [AW-1:0] addr;
    } ent_t;

    typedef struct packed {
        ent_t [NUM_ID-1:0] ent;
        logic              err;
        logic              rsp_v;
        logic [IDW-1:0]    rsp_id;
        logic [DW-1:0]     rsp_data;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_ID-1:0]     free_v, issue_v, retry_v, drop_v;
    logic                  retry_found, issue_found;
    logic [IDW-1:0]        retry_idx, issue_idx, sel;
    logic                  tc_hit, tc_ins_v, rsp_live;
    logic [TC_ENTRIES-1:0] tc_occ;

    for (genvar g = 0; g < NUM_ID; g++) begin : g_vec
        assign free_v[g]  = (st_q.ent[g].st == ENT_FREE);
        assign issue_v[g] = (st_q.ent[g].st == ENT_ISSUE);
        assign retry_v[g] = (st_q.ent[g].st == ENT_RETRY);
        assign drop_v[g]  = st_q.ent[g].drop;
    end

    spg_pick #(.N(NUM_ID)) u_pick_free  (.vec(free_v),  .found(req_ready),   .idx(req_gnt_id));
    spg_pick #(.N(NUM_ID)) u_pick_retry (.vec(retry_v), .found(retry_found), .idx(retry_idx));
    spg_pick #(.N(NUM_ID)) u_pick_issue (.vec(issue_v), .found(issue_found), .idx(issue_idx));

    // committed parked reads are served ahead of unsent ones (R8)
    assign sel           = retry_found ? retry_idx : issue_idx;
    assign bus_req_valid = retry_found || issue_found;
    assign bus_req_id    = sel;
    assign bus_req_addr  = st_q.ent[sel].addr;
    assign bus_req_spec  = st_q.ent[sel].spec;

    assign rsp_live = bus_rsp_valid && (st_q.ent[bus_rsp_id].st == ENT_INFL);
    assign tc_ins_v = rsp_live && bus_rsp_nack && bus_rsp_io;

    spg_type_cache #(.ENTRIES(TC_ENTRIES), .PW(PW)) u_tc (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (tc_flush),
        .lk_page  (req_addr[AW-1:PAGE_SHIFT]),
        .lk_hit   (tc_hit),
        .ins_v    (tc_ins_v),
        .ins_page (st_q.ent[bus_rsp_id].addr[AW-1:PAGE_SHIFT]),
        .occ      (tc_occ)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;

        // issue: the tag leaves with the read as it stands now (R1)
        if (bus_req_valid && bus_req_ready) begin
            st_d.ent[sel].st        = ENT_INFL;
            st_d.ent[sel].sent_spec = st_q.ent[sel].spec;
        end

        // response
        if (rsp_live) begin
            if (bus_rsp_nack) begin
                if (!st_q.ent[bus_rsp_id].sent_spec) st_d.err = 1'b1;
                if (st_q.ent[bus_rsp_id].drop || !st_q.ent[bus_rsp_id].sent_spec) begin
                    st_d.ent[bus_rsp_id].st   = ENT_FREE;
                    st_d.ent[bus_rsp_id].drop = 1'b0;
                end else if (!st_q.ent[bus_rsp_id].spec) begin
                    st_d.ent[bus_rsp_id].st = ENT_RETRY;
                end else begin
                    st_d.ent[bus_rsp_id].st = ENT_PARK;
                end
            end else begin
                if (!st_q.ent[bus_rsp_id].drop) begin
                    st_d.rsp_v    = 1'b1;
                    st_d.rsp_id   = bus_rsp_id;
                    st_d.rsp_data = bus_rsp_data;
                end
                st_d.ent[bus_rsp_id].st   = ENT_FREE;
                st_d.ent[bus_rsp_id].drop = 1'b0;
            end
        end

        // commit or squash, seen after issue and response of this cycle
        if (cs_valid) begin
            case (st_d.ent[cs_id].st)
                ENT_ISSUE: begin
                    if (cs_squash) st_d.ent[cs_id].st = ENT_FREE;
                    else           st_d.ent[cs_id].spec = 1'b0;
                end
                ENT_INFL: begin
                    if (cs_squash) st_d.ent[cs_id].drop = 1'b1;
                    else           st_d.ent[cs_id].spec = 1'b0;
                end
                ENT_PARK: begin
                    if (cs_squash) begin
                        st_d.ent[cs_id].st = ENT_FREE;
                    end else begin
                        st_d.ent[cs_id].st   = ENT_RETRY;
                        st_d.ent[cs_id].spec = 1'b0;
                    end
                end
                ENT_RETRY: begin
                    if (cs_squash) st_d.ent[cs_id].st = ENT_FREE;
                end
                default: ;
            endcase
        end

        // accept a new read into the lowest free slot
        if (req_valid && req_ready) begin
            st_d.ent[req_gnt_id].addr      = req_addr;
            st_d.ent[req_gnt_id].spec      = req_spec;
            st_d.ent[req_gnt_id].sent_spec = 1'b0;
            st_d.ent[req_gnt_id].drop      = 1'b0;
            st_d.ent[req_gnt_id].st        = (req_spec && tc_hit) ? ENT_PARK : ENT_ISSUE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign core_rsp_valid = st_q.rsp_v;
    assign core_rsp_id    = st_q.rsp_id;
    assign core_rsp_data  = st_q.rsp_data;
    assign nack_err       = st_q.err;
endmodule

// File: rtl/spg_gate_chk.sv
module spg_gate_chk #(
    parameter int NUM_ID     = 8,
    parameter int TC_ENTRIES = 4,
    localparam int IDW = $clog2(NUM_ID)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tc_flush,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [IDW-1:0]        req_gnt_id,
    input logic                  bus_req_valid,
    input logic [IDW-1:0]        bus_req_id,
    input logic                  bus_req_spec,
    input logic                  bus_rsp_valid,
    input logic [IDW-1:0]        bus_rsp_id,
    input logic                  bus_rsp_nack,
    input logic                  core_rsp_valid,
    input logic                  nack_err,
    input logic [NUM_ID-1:0]     free_v,
    input logic [NUM_ID-1:0]     issue_v,
    input logic [NUM_ID-1:0]     retry_v,
    input logic [NUM_ID-1:0]     drop_v,
    input logic [TC_ENTRIES-1:0] tc_occ
);
    assert_slot_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !free_v[$past(req_gnt_id)]);

    assert_issue_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (issue_v[bus_req_id] || retry_v[bus_req_id]));

    assert_retry_untagged_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && retry_v[bus_req_id]) |-> !bus_req_spec);

    assert_retry_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && (retry_v != '0)) |-> retry_v[bus_req_id]);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nack_err |=> nack_err);

    assert_data_forward_R10: assert property (@(posedge clk) disable iff (!rst_n)
        core_rsp_valid |-> $past(bus_rsp_valid && !bus_rsp_nack));

    assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rsp_valid && drop_v[bus_rsp_id]) |=> !core_rsp_valid);

    assert_flush_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tc_flush |=> (tc_occ == '0));
endmodule

bind spg_gate spg_gate_chk #(.NUM_ID(NUM_ID), .TC_ENTRIES(TC_ENTRIES)) u_chk (.*);

// File: tb/spg_gate_tb.sv
module spg_gate_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tc_flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_spec = 1'b0;
    logic        req_ready;
    logic [2:0]  req_gnt_id;
    logic        cs_valid = 1'b0;
    logic [2:0]  cs_id = '0;
    logic        cs_squash = 1'b0;
    logic        bus_req_valid;
    logic        bus_req_ready = 1'b1;
    logic [2:0]  bus_req_id;
    logic [31:0] bus_req_addr;
    logic        bus_req_spec;
    logic        bus_rsp_valid = 1'b0;
    logic [2:0]  bus_rsp_id = '0;
    logic        bus_rsp_nack = 1'b0;
    logic        bus_rsp_io = 1'b0;
    logic [31:0] bus_rsp_data = '0;
    logic        core_rsp_valid;
    logic [2:0]  core_rsp_id;
    logic [31:0] core_rsp_data;
    logic        nack_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spg_gate dut_i (.*);

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    typedef struct { int id; logic [31:0] addr; bit spec; int due; } tq_t;
    tq_t tq[$];
    int  cyc = 0;
    bit  force_nack = 1'b0;
    int  lg_id[$];
    bit  lg_spec[$];
    int  rsp_cnt[8];
    logic [31:0] rsp_dat[8];

    function automatic bit is_io(input logic [31:0] a);
        return a[31:16] == 16'h8000;
    endfunction

    always @(negedge clk) begin
        cyc++;
        bus_rsp_valid <= 1'b0;
        if (tq.size() > 0 && tq[0].due <= cyc) begin
            tq_t t;
            t = tq.pop_front();
            bus_rsp_valid <= 1'b1;
            bus_rsp_id    <= 3'(t.id);
            bus_rsp_io    <= is_io(t.addr);
            bus_rsp_nack  <= (t.spec && is_io(t.addr)) || (force_nack && !t.spec);
            bus_rsp_data  <= t.addr ^ 32'h5A5A_0F0F;
        end
        if (rst_n && bus_req_valid && bus_req_ready) begin
            tq.push_back('{int'(bus_req_id), bus_req_addr, bus_req_spec, cyc + 3});
            lg_id.push_back(int'(bus_req_id));
            lg_spec.push_back(bus_req_spec);
        end
        if (rst_n && core_rsp_valid) begin
            rsp_cnt[core_rsp_id]++;
            rsp_dat[core_rsp_id] = core_rsp_data;
        end
    end

    // ---------------- reference model ----------------
    // slot codes: 0 free, 1 waiting to send, 2 on bus, 3 parked, 4 committed parked
    int          m_st[8];
    bit          m_spec[8], m_sent[8], m_drop[8];
    logic [31:0] m_addr[8];
    logic [19:0] m_pg[4];
    bit          m_pv[4];
    int          m_rr;
    bit          m_err, m_rv;
    int          m_rid;
    logic [31:0] m_rdata;

    function automatic int mpick(input int s);
        for (int i = 0; i < 8; i++) if (m_st[i] == s) return i;
        return -1;
    endfunction

    function automatic int msel();
        if (mpick(4) >= 0) return mpick(4);
        return mpick(1);
    endfunction

    always @(posedge clk) begin
        int  s, r, f;
        bit  hit, known;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_st[i] = 0; m_spec[i] = 0; m_sent[i] = 0; m_drop[i] = 0; m_addr[i] = '0;
            end
            for (int k = 0; k < 4; k++) begin m_pv[k] = 0; m_pg[k] = '0; end
            m_rr = 0; m_err = 0; m_rv = 0; m_rid = 0; m_rdata = '0;
        end else begin
            s = msel();
            f = mpick(0);
            hit = 0;
            for (int k = 0; k < 4; k++) if (m_pv[k] && m_pg[k] == req_addr[31:12]) hit = 1;
            m_rv = 0;
            if (s >= 0 && bus_req_ready) begin m_st[s] = 2; m_sent[s] = m_spec[s]; end
            r = int'(bus_rsp_id);
            if (bus_rsp_valid && m_st[r] == 2) begin
                if (bus_rsp_nack) begin
                    if (bus_rsp_io) begin
                        known = 0;
                        for (int k = 0; k < 4; k++)
                            if (m_pv[k] && m_pg[k] == m_addr[r][31:12]) known = 1;
                        if (!known && !tc_flush) begin
                            m_pg[m_rr] = m_addr[r][31:12]; m_pv[m_rr] = 1; m_rr = (m_rr + 1) % 4;
                        end
                    end
                    if (!m_sent[r]) m_err = 1;
                    if (m_drop[r] || !m_sent[r]) begin m_st[r] = 0; m_drop[r] = 0; end
                    else if (!m_spec[r]) m_st[r] = 4;
                    else m_st[r] = 3;
                end else begin
                    if (!m_drop[r]) begin m_rv = 1; m_rid = r; m_rdata = bus_rsp_data; end
                    m_st[r] = 0; m_drop[r] = 0;
                end
            end
            if (tc_flush) begin
                for (int k = 0; k < 4; k++) m_pv[k] = 0;
                m_rr = 0;
            end
            if (cs_valid) begin
                r = int'(cs_id);
                case (m_st[r])
                    1: if (cs_squash) m_st[r] = 0; else m_spec[r] = 0;
                    2: if (cs_squash) m_drop[r] = 1; else m_spec[r] = 0;
                    3: if (cs_squash) m_st[r] = 0; else begin m_st[r] = 4; m_spec[r] = 0; end
                    4: if (cs_squash) m_st[r] = 0;
                    default: ;
                endcase
            end
            if (req_valid && f >= 0) begin
                m_addr[f] = req_addr; m_spec[f] = req_spec; m_sent[f] = 0; m_drop[f] = 0;
                m_st[f] = (req_spec && hit) ? 3 : 1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        int s, f;
        if (rst_n) begin
            s = msel();
            f = mpick(0);
            check(bus_req_valid == (s >= 0), "R8", "bus_req_valid", 64'(bus_req_valid), 64'(s >= 0));
            if (s >= 0) begin
                check(int'(bus_req_id) == s, "R8", "bus_req_id", 64'(bus_req_id), 64'(s));
                check(bus_req_addr == m_addr[s], "R8", "bus_req_addr", 64'(bus_req_addr), 64'(m_addr[s]));
                check(bus_req_spec == m_spec[s], "R1", "bus_req_spec", 64'(bus_req_spec), 64'(m_spec[s]));
            end
            check(req_ready == (f >= 0), "R6", "req_ready", 64'(req_ready), 64'(f >= 0));
            if (f >= 0)
                check(int'(req_gnt_id) == f, "R6", "req_gnt_id", 64'(req_gnt_id), 64'(f));
            check(core_rsp_valid == m_rv, "R10", "core_rsp_valid", 64'(core_rsp_valid), 64'(m_rv));
            if (m_rv) begin
                check(int'(core_rsp_id) == m_rid, "R10", "core_rsp_id", 64'(core_rsp_id), 64'(m_rid));
                check(core_rsp_data == m_rdata, "R10", "core_rsp_data", 64'(core_rsp_data), 64'(m_rdata));
            end
            check(nack_err == m_err, "R9", "nack_err", 64'(nack_err), 64'(m_err));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_req(input logic [31:0] a, input bit sp, output int id);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_spec = sp;
        id = int'(req_gnt_id);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_cs(input int id, input bit sq);
        cs_valid = 1'b1; cs_id = 3'(id); cs_squash = sq;
        @(negedge clk);
        cs_valid = 1'b0;
    endtask

    task automatic do_flush();
        tc_flush = 1'b1;
        @(negedge clk);
        tc_flush = 1'b0;
    endtask

    // speculative read that is squashed after its outcome settles; returns bus requests sent
    task automatic probe(input logic [31:0] a, output int delta);
        int b0, id;
        b0 = lg_id.size();
        do_req(a, 1'b1, id);
        wait_n(10);
        delta = lg_id.size() - b0;
        do_cs(id, 1'b1);
        wait_n(2);
    endtask

    localparam logic [31:0] MEM  = 32'h0000_4000;
    localparam logic [31:0] PG_A = 32'h8000_0010;

    initial begin
        int id, id2, id3, b0, r0, d, L;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R6, R9)
        check(req_ready == 1'b1, "R6", "reset req_ready", 64'(req_ready), 64'd1);
        check(req_gnt_id == 3'd0, "R6", "reset req_gnt_id", 64'(req_gnt_id), 64'd0);
        check(bus_req_valid == 1'b0, "R1", "reset bus_req_valid", 64'(bus_req_valid), 64'd0);
        check(nack_err == 1'b0, "R9", "reset nack_err", 64'(nack_err), 64'd0);
        wait_n(1);

        // R10 and R1: plain reads
        do_req(MEM, 1'b0, id);
        wait_n(8);
        check(rsp_cnt[id] == 1, "R10", "non-spec read returned", 64'(rsp_cnt[id]), 64'd1);
        check(rsp_dat[id] == (MEM ^ 32'h5A5A_0F0F), "R10", "data", 64'(rsp_dat[id]), 64'(MEM ^ 32'h5A5A_0F0F));
        check(lg_spec[lg_spec.size()-1] == 1'b0, "R1", "non-spec tag", 64'(lg_spec[lg_spec.size()-1]), 64'd0);
        do_req(MEM + 32'h40, 1'b1, id);
        wait_n(8);
        check(lg_spec[lg_spec.size()-1] == 1'b1, "R1", "spec tag", 64'(lg_spec[lg_spec.size()-1]), 64'd1);
        check(rsp_cnt[id] == 2, "R10", "spec mem read returned", 64'(rsp_cnt[id]), 64'd2);

        // R2: refusal parks, commit resends untagged
        b0 = lg_id.size();
        do_req(PG_A, 1'b1, id);
        wait_n(12);
        check(lg_id.size() - b0 == 1, "R2", "parked read not resent", 64'(lg_id.size() - b0), 64'd1);
        r0 = rsp_cnt[id];
        do_cs(id, 1'b0);
        wait_n(8);
        check(lg_id.size() - b0 == 2, "R2", "resent after commit", 64'(lg_id.size() - b0), 64'd2);
        check(lg_spec[lg_spec.size()-1] == 1'b0, "R2", "resent tag", 64'(lg_spec[lg_spec.size()-1]), 64'd0);
        check(rsp_cnt[id] == r0 + 1, "R2", "committed read returned", 64'(rsp_cnt[id]), 64'(r0 + 1));

        // R3: learned page held locally
        b0 = lg_id.size();
        do_req(PG_A + 32'h100, 1'b1, id);
        wait_n(10);
        check(lg_id.size() == b0, "R3", "held without bus", 64'(lg_id.size() - b0), 64'd0);
        do_cs(id, 1'b0);
        wait_n(8);
        check(lg_id.size() - b0 == 1, "R3", "sent after commit", 64'(lg_id.size() - b0), 64'd1);
        check(lg_spec[lg_spec.size()-1] == 1'b0, "R3", "sent untagged", 64'(lg_spec[lg_spec.size()-1]), 64'd0);

        // R4: non-spec to learned page goes out
        b0 = lg_id.size();
        r0 = 0;
        do_req(PG_A, 1'b0, id);
        r0 = rsp_cnt[id];
        wait_n(8);
        check(lg_id.size() - b0 == 1, "R4", "non-spec on io page sent", 64'(lg_id.size() - b0), 64'd1);
        check(rsp_cnt[id] == r0 + 1, "R4", "non-spec io data", 64'(rsp_cnt[id]), 64'(r0 + 1));

        // R7: squash of parked read
        b0 = lg_id.size();
        do_req(PG_A, 1'b1, id);
        r0 = rsp_cnt[id];
        do_cs(id, 1'b1);
        wait_n(8);
        check(lg_id.size() == b0, "R7", "parked squash no bus", 64'(lg_id.size() - b0), 64'd0);
        check(rsp_cnt[id] == r0, "R7", "parked squash no data", 64'(rsp_cnt[id]), 64'(r0));
        // R7: squash on the same edge as issue
        b0 = lg_id.size();
        do_req(MEM + 32'h80, 1'b1, id);
        r0 = rsp_cnt[id];
        do_cs(id, 1'b1);
        wait_n(10);
        check(lg_id.size() - b0 == 1, "R7", "in-flight squash was sent", 64'(lg_id.size() - b0), 64'd1);
        check(rsp_cnt[id] == r0, "R7", "in-flight squash dropped", 64'(rsp_cnt[id]), 64'(r0));
        // R7: squash before issue
        bus_req_ready = 1'b0;
        b0 = lg_id.size();
        do_req(MEM + 32'hC0, 1'b1, id);
        do_cs(id, 1'b1);
        bus_req_ready = 1'b1;
        wait_n(6);
        check(lg_id.size() == b0, "R7", "unsent squash no bus", 64'(lg_id.size() - b0), 64'd0);

        // R8: committed parked reads before unsent, lowest id first
        bus_req_ready = 1'b0;
        do_req(MEM + 32'h100, 1'b0, id);
        do_req(PG_A, 1'b1, id2);
        do_req(PG_A, 1'b1, id3);
        do_cs(id3, 1'b0);
        do_cs(id2, 1'b0);
        L = lg_id.size();
        bus_req_ready = 1'b1;
        wait_n(12);
        check(lg_id[L] == id2, "R8", "first issue", 64'(lg_id[L]), 64'(id2));
        check(lg_id[L+1] == id3, "R8", "second issue", 64'(lg_id[L+1]), 64'(id3));
        check(lg_id[L+2] == id, "R8", "unsent read last", 64'(lg_id[L+2]), 64'(id));

        // R5: round-robin fill, eviction and flush
        do_flush();
        probe(32'h8000_0000, d); check(d == 1, "R5", "page0 miss", 64'(d), 64'd1);
        probe(32'h8000_1000, d); check(d == 1, "R5", "page1 miss", 64'(d), 64'd1);
        probe(32'h8000_2000, d); check(d == 1, "R5", "page2 miss", 64'(d), 64'd1);
        probe(32'h8000_3000, d); check(d == 1, "R5", "page3 miss", 64'(d), 64'd1);
        probe(32'h8000_2008, d); check(d == 0, "R3", "page2 hit", 64'(d), 64'd0);
        probe(32'h8000_4000, d); check(d == 1, "R5", "page4 miss", 64'(d), 64'd1);
        probe(32'h8000_0000, d); check(d == 1, "R5", "page0 evicted", 64'(d), 64'd1);
        probe(32'h8000_3000, d); check(d == 0, "R5", "page3 kept", 64'(d), 64'd0);
        do_flush();
        probe(32'h8000_3000, d); check(d == 1, "R5", "page3 after flush", 64'(d), 64'd1);

        // R6: all slots busy
        bus_req_ready = 1'b0;
        for (int i = 0; i < 8; i++) begin
            int k;
            do_req(MEM + 32'(i * 64), 1'b0, k);
            check(k == i, "R6", "grant order", 64'(k), 64'(i));
        end
        check(req_ready == 1'b0, "R6", "stall when full", 64'(req_ready), 64'd0);
        for (int i = 0; i < 8; i++) rsp_dat[i] = '0;
        bus_req_ready = 1'b1;
        wait_n(20);
        for (int i = 0; i < 8; i++)
            check(rsp_dat[i] == ((MEM + 32'(i * 64)) ^ 32'h5A5A_0F0F), "R6", "slot data",
                  64'(rsp_dat[i]), 64'((MEM + 32'(i * 64)) ^ 32'h5A5A_0F0F));

        // R9: refusal of non-spec read
        force_nack = 1'b1;
        do_req(MEM, 1'b0, id);
        r0 = rsp_cnt[id];
        wait_n(10);
        force_nack = 1'b0;
        check(nack_err == 1'b1, "R9", "error set", 64'(nack_err), 64'd1);
        check(rsp_cnt[id] == r0, "R9", "nothing forwarded", 64'(rsp_cnt[id]), 64'(r0));
        do_req(MEM, 1'b0, id);
        wait_n(10);
        check(nack_err == 1'b1, "R9", "error sticky", 64'(nack_err), 64'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule